// File: doc/BRIEF.md
# Bit Scan and Zero-Count Unit

This execution unit returns the position of the lowest or highest set bit of a source operand, or counts its trailing or leading zeros. It handles 16, 32 and 64-bit operands. The issue stage presents one operation per valid strobe with the source, the old destination value, a size code, a direction select, a repeat-prefix flag and a feature-enable flag. One clock later the unit returns the destination value, a write-enable and the zero and carry flags.

The legacy scans leave the destination alone when the source is zero, and they report that case only through the zero flag. When the count feature is enabled, the repeat prefix turns a scan into a zero count. A zero count always writes the destination, and a zero source produces the operand width with carry set. When the feature is disabled, the prefix is ignored.

Top module: `bit_scan_unit`

## Requirements
- R1: `op_size` selects the operand width: 2'b00 is 16 bits, 2'b01 is 32 bits, and 2'b10 or 2'b11 is 64 bits. Source bits above the selected width have no effect on any output.
- R2: A forward scan (`op_rev`=0) in scan mode with a nonzero source returns the index of the lowest set bit, with `zf`=0, `cf`=0 and `dst_we`=1.
- R3: A reverse scan (`op_rev`=1) in scan mode with a nonzero source returns the index of the highest set bit, with `zf`=0, `cf`=0 and `dst_we`=1.
- R4: A scan-mode operation with a zero source gives `zf`=1, `cf`=0 and `dst_we`=0, and `dst_result` equals the `dst_old` value that came with the operation.
- R5: Count mode applies only when `rep_f3` and `cnt_en` are both 1. With `cnt_en`=0 the prefix is ignored and the operation behaves as a scan.
- R6: A trailing-zero count with a nonzero source returns the index of the lowest set bit, with `cf`=0, `dst_we`=1, and `zf`=1 exactly when the result is 0.
- R7: A leading-zero count with a nonzero source returns width-1 minus the index of the highest set bit, with `cf`=0, `dst_we`=1, and `zf`=1 exactly when the result is 0.
- R8: A count-mode operation with a zero source returns the operand width (16, 32 or 64), with `cf`=1, `zf`=0 and `dst_we`=1.
- R9: `out_valid` rises one cycle after each `in_valid` cycle. `dst_we` is never 1 while `out_valid` is 0. Reset clears `out_valid`, `dst_we`, `zf`, `cf` and `dst_result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src | input | 64 | Source operand |
| dst_old | input | 64 | Current destination value |
| op_size | input | 2 | Operand width code |
| op_rev | input | 1 | 0 selects forward/trailing, 1 selects reverse/leading |
| rep_f3 | input | 1 | Repeat prefix present |
| cnt_en | input | 1 | Count extension enabled |
| out_valid | output | 1 | Result valid |
| dst_result | output | 64 | Destination value |
| dst_we | output | 1 | Destination write enable |
| zf | output | 1 | Zero flag |
| cf | output | 1 | Carry flag |

## Verification
Every result, flag and write-enable is due exactly one clock edge after the strobe that carries the operation, and none of them earlier. The bench drives each operation on a falling edge and samples all outputs on the next falling edge, which sits between the single register stage and the following edge. It then drops the strobe and samples again one falling edge later, to confirm that the valid and write-enable outputs return low after that one cycle.

// File: rtl/bsu_pkg.sv
// Package: shared widths, size encoding and the width lookup for the
// bit scan unit. Assumes a 64-bit datapath.
package bsu_pkg;
    localparam int XLEN = 64;
    localparam int IW   = $clog2(XLEN);
    localparam int CW   = IW + 1;

    typedef enum logic [1:0] {
        SZ_W16  = 2'b00,
        SZ_W32  = 2'b01,
        SZ_W64  = 2'b10,
        SZ_W64B = 2'b11
    } opsz_e;

    // Operand width in bits for a size code
    function automatic logic [CW-1:0] size_bits(input opsz_e s);
        case (s)
            SZ_W16:  return CW'(16);
            SZ_W32:  return CW'(32);
            default: return CW'(64);
        endcase
    endfunction
endpackage

// File: rtl/bsu_operand_mask.sv
// Operand mask: clears source bits above the selected width and reports
// that width. Purely combinational.
module bsu_operand_mask
    import bsu_pkg::*;
(
    input  logic [XLEN-1:0] src,
    input  logic [1:0]      op_size,
    output logic [XLEN-1:0] masked,
    output logic [CW-1:0]   width
);
    opsz_e sz;

    // Decode the size code and keep only the in-width bits
    always_comb begin
        sz     = opsz_e'(op_size);
        width  = size_bits(sz);
        case (sz)
            SZ_W16:  masked = {{(XLEN-16){1'b0}}, src[15:0]};
            SZ_W32:  masked = {{(XLEN-32){1'b0}}, src[31:0]};
            default: masked = src;
        endcase
    end
endmodule

// File: rtl/bsu_scan.sv
// Priority scan: finds the index of the lowest (FROM_TOP=0) or the highest
// (FROM_TOP=1) set bit. idx is 0 when no bit is set; found flags any set bit.
module bsu_scan #(
    parameter int W        = 64,
    parameter bit FROM_TOP = 1'b0,
    localparam int IDXW    = $clog2(W)
) (
    input  logic [W-1:0]    vec,
    output logic [IDXW-1:0] idx,
    output logic            found
);
    assign found = |vec;

    generate
        if (FROM_TOP) begin : g_high
            // Ascending walk: the last hit is the highest set bit
            always_comb begin
                idx = '0;
                for (int i = 0; i < W; i++)
                    if (vec[i]) idx = IDXW'(i);
            end
        end else begin : g_low
            // Descending walk: the last hit is the lowest set bit
            always_comb begin
                idx = '0;
                for (int i = W-1; i >= 0; i--)
                    if (vec[i]) idx = IDXW'(i);
            end
        end
    endgenerate
endmodule

// File: rtl/bit_scan_unit.sv
// Bit scan / zero count execution unit. Masks the source to the selected
// width, runs both priority scans, picks scan or count semantics, and
// registers result and flags one cycle after in_valid. Assumes the caller
// supplies the current destination value in dst_old.
module bit_scan_unit
    import bsu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [63:0]     src,
    input  logic [63:0]     dst_old,
    input  logic [1:0]      op_size,
    input  logic            op_rev,
    input  logic            rep_f3,
    input  logic            cnt_en,
    output logic            out_valid,
    output logic [63:0]     dst_result,
    output logic            dst_we,
    output logic            zf,
    output logic            cf
);
    logic [XLEN-1:0] masked;
    logic [CW-1:0]   width;
    logic [IW-1:0]   lo_idx, hi_idx;
    logic            lo_found, hi_found;
    logic            count_mode;
    logic [XLEN-1:0] nx_result;
    logic            nx_we, nx_zf, nx_cf;
    logic [CW-1:0]   cnt_val;

    bsu_operand_mask u_mask (
        .src     (src),
        .op_size (op_size),
        .masked  (masked),
        .width   (width)
    );

    bsu_scan #(.W(XLEN), .FROM_TOP(1'b0)) u_low (
        .vec   (masked),
        .idx   (lo_idx),
        .found (lo_found)
    );

    bsu_scan #(.W(XLEN), .FROM_TOP(1'b1)) u_high (
        .vec   (masked),
        .idx   (hi_idx),
        .found (hi_found)
    );

    assign count_mode = rep_f3 & cnt_en;

    // Select scan or count semantics and form next result and flags
    always_comb begin
        cnt_val   = '0;
        nx_result = dst_old;
        nx_we     = 1'b0;
        nx_zf     = 1'b0;
        nx_cf     = 1'b0;
        if (count_mode) begin
            if (!lo_found)   cnt_val = width;
            else if (op_rev) cnt_val = width - CW'(1) - CW'(hi_idx);
            else             cnt_val = CW'(lo_idx);
            nx_result = XLEN'(cnt_val);
            nx_we     = 1'b1;
            nx_cf     = !lo_found;
            nx_zf     = (cnt_val == '0);
        end else if (hi_found) begin
            nx_result = XLEN'(op_rev ? hi_idx : lo_idx);
            nx_we     = 1'b1;
        end else begin
            nx_zf     = 1'b1;
        end
    end

    // Output register stage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            dst_result <= '0;
            dst_we     <= 1'b0;
            zf         <= 1'b0;
            cf         <= 1'b0;
        end else begin
            out_valid <= in_valid;
            dst_we    <= in_valid & nx_we;
            if (in_valid) begin
                dst_result <= nx_result;
                zf         <= nx_zf;
                cf         <= nx_cf;
            end
        end
    end
endmodule

// File: rtl/bit_scan_unit_chk.sv
// Checker for bit_scan_unit: temporal properties on ports, bound below.
module bit_scan_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] src,
    input logic [63:0] dst_old,
    input logic [1:0]  op_size,
    input logic        rep_f3,
    input logic        cnt_en,
    input logic        out_valid,
    input logic [63:0] dst_result,
    input logic        dst_we,
    input logic        zf,
    input logic        cf
);
    logic [6:0] exp_w;
    assign exp_w = (op_size == 2'b00) ? 7'd16 : (op_size == 2'b01) ? 7'd32 : 7'd64;

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !dst_we); // R9
    AST_SCAN_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(rep_f3 && cnt_en) && src == 64'd0)
        |=> (zf && !dst_we && !cf && dst_result == $past(dst_old))); // R4
    AST_SCAN_ZF_VS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(rep_f3 && cnt_en)) |=> (zf == !dst_we) && !cf); // R5
    AST_COUNT_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rep_f3 && cnt_en && src == 64'd0)
        |=> (cf && !zf && dst_we && dst_result == {57'd0, $past(exp_w)})); // R8
    AST_COUNT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rep_f3 && cnt_en) |=> dst_we); // R6
endmodule

bind bit_scan_unit bit_scan_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .src        (src),
    .dst_old    (dst_old),
    .op_size    (op_size),
    .rep_f3     (rep_f3),
    .cnt_en     (cnt_en),
    .out_valid  (out_valid),
    .dst_result (dst_result),
    .dst_we     (dst_we),
    .zf         (zf),
    .cf         (cf)
);

// File: tb/sim_bit_scan_unit.sv
module sim_bit_scan_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src = '0, dst_old = '0;
    logic [1:0]  op_size = '0;
    logic        op_rev = 1'b0, rep_f3 = 1'b0, cnt_en = 1'b0;
    logic        out_valid, dst_we, zf, cf;
    logic [63:0] dst_result;
    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bit_scan_unit u0 (.*);

    // Reference model built from the requirements
    task automatic model(input logic [63:0] s, input logic [63:0] d, input logic [1:0] sz,
                         input logic rv, input logic rp, input logic en,
                         output logic [63:0] r, output logic we, output logic z, output logic c);
        int w, lo, hi;
        logic [63:0] m;
        w = (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;
        m = (w == 64) ? s : (s & ((64'd1 << w) - 64'd1));
        lo = -1; hi = -1;
        for (int i = 0; i < 64; i++) if (m[i]) begin hi = i; if (lo < 0) lo = i; end
        if (rp && en) begin
            if (m == 0) r = 64'(w);
            else if (rv) r = 64'(w - 1 - hi);
            else r = 64'(lo);
            we = 1; c = (m == 0); z = (r == 0);
        end else if (m != 0) begin
            r = 64'(rv ? hi : lo); we = 1; z = 0; c = 0;
        end else begin
            r = d; we = 0; z = 1; c = 0;
        end
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input string req, input logic [63:0] s, input logic [63:0] d,
                       input logic [1:0] sz, input logic rv, input logic rp, input logic en);
        logic [63:0] er; logic ewe, ez, ec;
        model(s, d, sz, rv, rp, en, er, ewe, ez, ec);
        @(negedge clk);
        src = s; dst_old = d; op_size = sz; op_rev = rv; rep_f3 = rp; cnt_en = en; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        chk({req, " R9 out_valid"}, 64'(out_valid), 64'd1);
        chk({req, " result"}, dst_result, er);
        chk({req, " we"}, 64'(dst_we), 64'(ewe));
        chk({req, " zf"}, 64'(zf), 64'(ez));
        chk({req, " cf"}, 64'(cf), 64'(ec));
        @(negedge clk);
        chk("R9 idle valid", 64'(out_valid), 64'd0);
        chk("R9 idle we", 64'(dst_we), 64'd0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R9 reset valid", 64'(out_valid), 64'd0);
        chk("R9 reset we", 64'(dst_we), 64'd0);
        chk("R9 reset zf", 64'(zf), 64'd0);
        chk("R9 reset cf", 64'(cf), 64'd0);
        chk("R9 reset result", dst_result, 64'd0);
        // Directed corner cases
        run("R2", 64'h0000_0000_0000_0100, 64'hAAAA, 2'b10, 0, 0, 0);
        run("R3", 64'h8000_0000_0000_0001, 64'hAAAA, 2'b10, 1, 0, 0);
        run("R4", 64'd0, 64'hDEAD_BEEF_1234_5678, 2'b10, 0, 0, 0);
        run("R4", 64'd0, 64'h0123_4567_89AB_CDEF, 2'b00, 1, 0, 0);
        run("R1", 64'hFFFF_FFFF_FFFF_0000, 64'h5555, 2'b00, 0, 0, 0);
        run("R1", 64'hFFFF_0000_0000_0000, 64'h7777, 2'b01, 1, 1, 1);
        run("R1", 64'h0000_0000_0001_0000, 64'h1, 2'b00, 1, 1, 1);
        run("R5", 64'h0000_0000_0000_0010, 64'h1, 2'b10, 0, 1, 0);
        run("R5", 64'd0, 64'h9999, 2'b01, 1, 1, 0);
        run("R6", 64'h0000_0000_0000_0001, 64'h1, 2'b10, 0, 1, 1);
        run("R6", 64'h8000_0000_0000_0000, 64'h1, 2'b10, 0, 1, 1);
        run("R7", 64'h0000_0000_0000_8000, 64'h1, 2'b00, 1, 1, 1);
        run("R7", 64'h0000_0000_0000_0001, 64'h1, 2'b01, 1, 1, 1);
        run("R8", 64'd0, 64'h1, 2'b00, 0, 1, 1);
        run("R8", 64'd0, 64'h1, 2'b01, 1, 1, 1);
        run("R8", 64'd0, 64'h1, 2'b11, 0, 1, 1);
        // Constrained random: sparse sources to exercise zero and edges
        for (int k = 0; k < 400; k++) begin
            logic [63:0] s;
            s = {$urandom, $urandom};
            case ($urandom_range(0, 3))
                0: s = 64'd0;
                1: s = 64'd1 << $urandom_range(0, 63);
                2: s = s & {$urandom, $urandom};
                default: ;
            endcase
            run("R2 R3 R6 R7 random", s, {$urandom, $urandom}, 2'($urandom_range(0, 3)),
                1'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule